// File: doc/BRIEF.md
# Frame CRC Memory Scrubber

This block keeps a small on-chip memory under continuous watch. The memory holds a number of frames. Each frame is a run of 16-bit data words followed by one 16-bit check word. A sequencer reads every frame a word at a time and feeds its bits, most significant bit first, through a bit-serial CRC-16 engine. The check word goes through the same engine after the data words. A good frame leaves a zero residue, and any other residue marks the frame as failed. After the last frame the scan returns to frame 0, and it keeps running whether or not a frame has failed.

A failure sets a latched error output and records the index of the failing frame. Both stay in place until a clear pulse. The residue of frame 0 is captured on every pass into a dedicated 16-bit register, which can be shifted out serially without stopping the scan. A second memory port lets the surrounding logic load and inspect the frame contents. A self-test port can flip one bit, two independent bits, or two neighbouring bits. The flips are applied only at a frame boundary, so no frame is ever checked against half-modified contents.

Top module: `crc_scrubber`

## Requirements
- R1: While reset is high and in the first cycle after it, err_flag, err_frame, inj_busy and sig_dout are all 0. The memory contents are all zero after configuration, so every frame starts out valid.
- R2: Frame f occupies words f*(DATA_WORDS+1) to f*(DATA_WORDS+1)+DATA_WORDS. Its last word is the check word. The engine uses polynomial 0x1021, starts from zero at each frame and takes words MSB first. A frame passes when the residue after the check word is zero. If every frame is valid, err_flag stays low.
- R3: When a frame ends with a nonzero residue, err_flag goes high and err_frame takes that frame's index. Both then hold their values while no further frame fails and no clear is given.
- R4: Scanning continues after a failure and wraps from the last frame to frame 0. A later failing frame overwrites err_frame even while err_flag is already high.
- R5: A one-cycle err_clr pulse sets err_flag and err_frame to 0 on the next edge. If a frame fails in that same cycle, the failure wins.
- R6: Each time frame 0 ends, its 16-bit residue is copied into a signature register. A sig_load pulse copies the signature into the serial output register, and sig_dout then shows bit 15. Each cycle with sig_shift high moves the next lower bit to sig_dout. With neither input high, sig_dout holds its value.
- R7: A memory bit position p names word p/16, bit p%16, where bit 0 is the LSB. inj_mode 01 flips bit inj_pos_a. Mode 10 flips bits inj_pos_a and inj_pos_b. Mode 11 flips inj_pos_a and inj_pos_a+1, and wraps to position 0 from the last bit of the memory. Mode 00 changes nothing and is not accepted. Positions must be below the memory size in bits.
- R8: A request with inj_busy low and a nonzero mode is accepted, and inj_busy is high on the next cycle. The flips are written after the frame in progress completes, and inj_busy falls once they are in memory. Requests made while inj_busy is high are ignored.
- R9: On the host port, a write with host_we high updates the addressed word. host_rdata shows the addressed word one cycle after the address, including any injected flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W (6) | Host port word address |
| host_we | input | 1 | Host port write enable |
| host_wdata | input | 16 | Host port write data |
| host_rdata | output | 16 | Host port read data, one cycle latency |
| inj_req | input | 1 | Bit-flip request strobe |
| inj_mode | input | 2 | 00 none, 01 single, 10 double, 11 adjacent pair |
| inj_pos_a | input | POS_W (10) | First bit position |
| inj_pos_b | input | POS_W (10) | Second bit position for double mode |
| inj_busy | output | 1 | A flip request is pending or being written |
| err_clr | input | 1 | Clears the error latch |
| err_flag | output | 1 | Latched CRC failure, active high |
| err_frame | output | FIDX_W (2) | Index of the most recent failing frame |
| sig_load | input | 1 | Copies the frame-0 signature into the serial register |
| sig_shift | input | 1 | Advances the serial signature by one bit |
| sig_dout | output | 1 | Serial signature bit, MSB first |

## Verification
The hardest case to reach from the ports is a frame that fails while the error latch already holds an older frame. Observing it needs a corrupted frame, a repair, and a second corruption elsewhere, all with no clear in between. The bench builds this by editing words through the host port, waiting two full scan passes after each edit, and only then sampling err_frame. The random flip trials work the same way, repairing and clearing after each one. Requests issued while a flip is still pending, and an adjacent flip that wraps from the last bit of the memory to the first, are added as directed cases.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int WORD_W = 16;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    INJ_NONE   = 2'b00,
    INJ_SINGLE = 2'b01,
    INJ_DOUBLE = 2'b10,
    INJ_ADJ    = 2'b11
  } inj_mode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_LOAD,
    ST_SHIFT,
    ST_CHECK,
    ST_INJ_RD,
    ST_INJ_WR
  } seq_state_e;
endpackage

// File: rtl/scrub_mem.sv
module scrub_mem
  import scrub_pkg::*;
#(
  parameter int DEPTH = 36,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic [AW-1:0]     a_addr,
  input  logic              a_we,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  input  logic [AW-1:0]     b_addr,
  input  logic              b_we,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata
);
  logic [WORD_W-1:0] store [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = '0;
  end

  // Port A: scanner and flip engine. Port B: host. Port B wins on a same-address write.
  always_ff @(posedge clk) begin
    if (a_we) store[a_addr] <= a_wdata;
    if (b_we) store[b_addr] <= b_wdata;
    a_rdata <= store[a_addr];
    b_rdata <= store[b_addr];
  end
endmodule

// File: rtl/scrub_crc16.sv
module scrub_crc16
  import scrub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              din,
  output logic [WORD_W-1:0] crc
);
  logic fb;
  assign fb = crc[WORD_W-1] ^ din;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= {crc[WORD_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_pkg::*;
#(
  parameter int DATA_WORDS = 8,
  parameter int FRAMES = 4,
  localparam int FRAME_LEN = DATA_WORDS + 1,
  localparam int DEPTH = FRAME_LEN * FRAMES,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + BIT_W,
  localparam int FIW = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int WIW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              inj_req,
  input  inj_mode_e         inj_mode,
  input  logic [PW-1:0]     inj_pos_a,
  input  logic [PW-1:0]     inj_pos_b,
  output logic              inj_busy,
  output logic [AW-1:0]     a_addr,
  output logic              a_we,
  output logic [WORD_W-1:0] a_wdata,
  input  logic [WORD_W-1:0] a_rdata,
  output logic              crc_en,
  output logic              crc_bit,
  output logic              crc_clr,
  input  logic [WORD_W-1:0] crc_val,
  output logic              frame_done,
  output logic              frame_fail,
  output logic [FIW-1:0]    frame_idx
);
  localparam logic [PW-1:0] LAST_POS = PW'(DEPTH * WORD_W - 1);

  seq_state_e        state;
  logic [AW-1:0]     addr;
  logic [WIW-1:0]    widx;
  logic [FIW-1:0]    fidx;
  logic [BIT_W-1:0]  bitcnt;
  logic [WORD_W-1:0] sr;
  logic              pend, two, sel;
  logic [PW-1:0]     pos0, pos1, cur_pos;
  logic [AW-1:0]     cur_word;
  logic [BIT_W-1:0]  cur_bit;
  logic              flips_done;

  assign cur_pos    = sel ? pos1 : pos0;
  assign cur_word   = cur_pos[PW-1:BIT_W];
  assign cur_bit    = cur_pos[BIT_W-1:0];
  assign inj_busy   = pend;
  assign frame_idx  = fidx;
  assign flips_done = (state == ST_INJ_WR) && (!two || sel);

  // Flip request capture; one request is held until the next frame boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      two  <= 1'b0;
      pos0 <= '0;
      pos1 <= '0;
    end else if (!pend) begin
      if (inj_req && inj_mode != INJ_NONE) begin
        pend <= 1'b1;
        pos0 <= inj_pos_a;
        two  <= (inj_mode != INJ_SINGLE);
        if (inj_mode == INJ_DOUBLE)  pos1 <= inj_pos_b;
        else if (inj_pos_a == LAST_POS) pos1 <= '0;
        else                         pos1 <= inj_pos_a + 1'b1;
      end
    end else if (flips_done) begin
      pend <= 1'b0;
    end
  end

  // Scan sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      addr   <= '0;
      widx   <= '0;
      fidx   <= '0;
      bitcnt <= '0;
      sr     <= '0;
      sel    <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          sr     <= a_rdata;
          bitcnt <= '0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          sr     <= {sr[WORD_W-2:0], 1'b0};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == BIT_W'(WORD_W - 1)) begin
            if (widx == WIW'(FRAME_LEN - 1)) begin
              state <= ST_CHECK;
            end else begin
              widx  <= widx + 1'b1;
              addr  <= addr + 1'b1;
              state <= ST_FETCH;
            end
          end
        end
        ST_CHECK: begin
          widx <= '0;
          sel  <= 1'b0;
          if (fidx == FIW'(FRAMES - 1)) begin
            fidx <= '0;
            addr <= '0;
          end else begin
            fidx <= fidx + 1'b1;
            addr <= addr + 1'b1;
          end
          state <= pend ? ST_INJ_RD : ST_FETCH;
        end
        ST_INJ_RD: state <= ST_INJ_WR;
        ST_INJ_WR: begin
          if (two && !sel) begin
            sel   <= 1'b1;
            state <= ST_INJ_RD;
          end else begin
            state <= ST_FETCH;
          end
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

  always_comb begin
    a_addr     = addr;
    a_we       = 1'b0;
    a_wdata    = a_rdata ^ (WORD_W'(1) << cur_bit);
    crc_en     = (state == ST_SHIFT);
    crc_bit    = sr[WORD_W-1];
    frame_done = (state == ST_CHECK);
    crc_clr    = frame_done;
    frame_fail = frame_done && (crc_val != '0);
    if (state == ST_INJ_RD || state == ST_INJ_WR) a_addr = cur_word;
    if (state == ST_INJ_WR) a_we = 1'b1;
  end
endmodule

// File: rtl/scrub_sigout.sv
module scrub_sigout
  import scrub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [WORD_W-1:0] cap_val,
  input  logic              sig_load,
  input  logic              sig_shift,
  output logic              sig_dout
);
  logic [WORD_W-1:0] sig_store;
  logic [WORD_W-1:0] sig_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_store <= '0;
      sig_sr    <= '0;
    end else begin
      if (cap) sig_store <= cap_val;
      if (sig_load)       sig_sr <= sig_store;
      else if (sig_shift) sig_sr <= {sig_sr[WORD_W-2:0], 1'b0};
    end
  end

  assign sig_dout = sig_sr[WORD_W-1];
endmodule

// File: rtl/crc_scrubber.sv
module crc_scrubber
  import scrub_pkg::*;
#(
  parameter int DATA_WORDS = 8,
  parameter int FRAMES = 4,
  localparam int DEPTH = (DATA_WORDS + 1) * FRAMES,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int POS_W = ADDR_W + BIT_W,
  localparam int FIDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              inj_req,
  input  logic [1:0]        inj_mode,
  input  logic [POS_W-1:0]  inj_pos_a,
  input  logic [POS_W-1:0]  inj_pos_b,
  output logic              inj_busy,
  input  logic              err_clr,
  output logic              err_flag,
  output logic [FIDX_W-1:0] err_frame,
  input  logic              sig_load,
  input  logic              sig_shift,
  output logic              sig_dout
);
  logic [ADDR_W-1:0] a_addr;
  logic              a_we;
  logic [WORD_W-1:0] a_wdata, a_rdata;
  logic              crc_en, crc_bit, crc_clr;
  logic [WORD_W-1:0] crc_val;
  logic              frame_done, frame_fail;
  logic [FIDX_W-1:0] frame_idx;

  scrub_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(host_addr), .b_we(host_we), .b_wdata(host_wdata), .b_rdata(host_rdata)
  );

  scrub_seq #(.DATA_WORDS(DATA_WORDS), .FRAMES(FRAMES)) u_seq (
    .clk(clk), .rst(rst),
    .inj_req(inj_req), .inj_mode(inj_mode_e'(inj_mode)),
    .inj_pos_a(inj_pos_a), .inj_pos_b(inj_pos_b), .inj_busy(inj_busy),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .crc_en(crc_en), .crc_bit(crc_bit), .crc_clr(crc_clr), .crc_val(crc_val),
    .frame_done(frame_done), .frame_fail(frame_fail), .frame_idx(frame_idx)
  );

  scrub_crc16 u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(crc_bit), .crc(crc_val)
  );

  scrub_sigout u_sig (
    .clk(clk), .rst(rst),
    .cap(frame_done && frame_idx == '0), .cap_val(crc_val),
    .sig_load(sig_load), .sig_shift(sig_shift), .sig_dout(sig_dout)
  );

  // Error latch: a new failure takes priority over a clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag  <= 1'b0;
      err_frame <= '0;
    end else if (frame_fail) begin
      err_flag  <= 1'b1;
      err_frame <= frame_idx;
    end else if (err_clr) begin
      err_flag  <= 1'b0;
      err_frame <= '0;
    end
  end
endmodule

// File: rtl/scrub_chk.sv
module scrub_chk #(
  parameter int FIW = 2
)(
  input logic           clk,
  input logic           rst,
  input logic           err_clr,
  input logic           err_flag,
  input logic [FIW-1:0] err_frame,
  input logic           frame_done,
  input logic           frame_fail,
  input logic [FIW-1:0] frame_idx,
  input logic           inj_req,
  input logic [1:0]     inj_mode,
  input logic           inj_busy,
  input logic           a_we,
  input logic           sig_load,
  input logic           sig_shift,
  input logic           sig_dout
);
  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_fail) |=> (err_flag && err_frame == $past(frame_idx)));

  // R3
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!err_clr && !frame_fail) |=> ($stable(err_flag) && $stable(err_frame)));

  // R5
  err_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !frame_fail) |=> (!err_flag && err_frame == '0));

  // R8
  inj_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (inj_req && !inj_busy && inj_mode != 2'b00) |=> inj_busy);

  // R7
  inj_none_chk: assert property (@(posedge clk) disable iff (rst)
    (inj_req && !inj_busy && inj_mode == 2'b00) |=> !inj_busy);

  // R8
  inj_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(inj_busy) |-> $past(a_we));

  // R8
  inj_gap_chk: assert property (@(posedge clk) disable iff (rst)
    a_we |-> !frame_done);

  // R6
  sig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sig_load && !sig_shift) |=> $stable(sig_dout));
endmodule

bind crc_scrubber scrub_chk #(.FIW(FIDX_W)) u_chk (
  .clk(clk), .rst(rst), .err_clr(err_clr), .err_flag(err_flag), .err_frame(err_frame),
  .frame_done(frame_done), .frame_fail(frame_fail), .frame_idx(frame_idx),
  .inj_req(inj_req), .inj_mode(inj_mode), .inj_busy(inj_busy), .a_we(a_we),
  .sig_load(sig_load), .sig_shift(sig_shift), .sig_dout(sig_dout)
);

// File: tb/test_crc_scrubber.sv
module test_crc_scrubber;
  localparam int DW    = 8;
  localparam int NF    = 4;
  localparam int FL    = DW + 1;
  localparam int DEPTH = FL * NF;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 4;
  localparam int FIW   = $clog2(NF);
  localparam int TOTAL = DEPTH * 16;
  localparam int PASS  = NF * (FL * 18 + 1);
  localparam int WAITC = 2 * PASS + 40;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] host_addr;
  logic          host_we;
  logic [15:0]   host_wdata, host_rdata;
  logic          inj_req;
  logic [1:0]    inj_mode;
  logic [PW-1:0] inj_pos_a, inj_pos_b;
  logic          inj_busy;
  logic          err_clr, err_flag;
  logic [FIW-1:0] err_frame;
  logic          sig_load, sig_shift, sig_dout;

  crc_scrubber #(.DATA_WORDS(DW), .FRAMES(NF)) i_crc_scrubber (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .inj_req(inj_req),
    .inj_mode(inj_mode), .inj_pos_a(inj_pos_a), .inj_pos_b(inj_pos_b),
    .inj_busy(inj_busy), .err_clr(err_clr), .err_flag(err_flag),
    .err_frame(err_frame), .sig_load(sig_load), .sig_shift(sig_shift),
    .sig_dout(sig_dout)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] mdl  [DEPTH];
  logic [15:0] good [DEPTH];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    r = c;
    for (int b = 15; b >= 0; b--) begin
      logic fb;
      fb = r[15] ^ w[b];
      r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [15:0] frame_res(input int f);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < FL; i++) r = crc_word(r, mdl[f*FL+i]);
    return r;
  endfunction

  function automatic int bad_mask();
    int m;
    m = 0;
    for (int f = 0; f < NF; f++) if (frame_res(f) != 16'h0) m |= (1 << f);
    return m;
  endfunction

  task automatic host_write(input int a, input logic [15:0] d);
    host_addr = AW'(a); host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    mdl[a] = d;
  endtask

  task automatic host_read(input int a, output logic [15:0] d);
    host_addr = AW'(a); host_we = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic fill_frame(input int f);
    logic [15:0] c;
    c = '0;
    for (int i = 0; i < DW; i++) begin
      host_write(f*FL+i, 16'($urandom));
      c = crc_word(c, mdl[f*FL+i]);
    end
    host_write(f*FL+DW, c);
  endtask

  task automatic flip_mdl(input int p);
    mdl[p/16][p%16] = ~mdl[p/16][p%16];
  endtask

  task automatic mem_compare(input string req);
    int mism;
    logic [15:0] d;
    mism = 0;
    for (int a = 0; a < DEPTH; a++) begin
      host_read(a, d);
      if (d != mdl[a]) mism++;
    end
    chk(req, "memory words differing from model", mism, 0);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (inj_busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk("R8", "inj_busy released", inj_busy, 0);
  endtask

  task automatic inject(input logic [1:0] mode, input int pa, input int pb);
    inj_mode = mode; inj_pos_a = PW'(pa); inj_pos_b = PW'(pb); inj_req = 1'b1;
    @(negedge clk);
    inj_req = 1'b0;
    chk((mode == 2'b00) ? "R7" : "R8", "inj_busy after request", inj_busy, (mode != 2'b00));
    wait_idle();
    if (mode != 2'b00) begin
      flip_mdl(pa);
      if (mode == 2'b10) flip_mdl(pb);
      else if (mode == 2'b11) flip_mdl((pa + 1) % TOTAL);
    end
  endtask

  task automatic read_sig(output logic [15:0] v);
    sig_load = 1'b1;
    @(negedge clk);
    sig_load = 1'b0;
    v[15] = sig_dout;
    for (int i = 14; i >= 0; i--) begin
      sig_shift = 1'b1;
      @(negedge clk);
      v[i] = sig_dout;
    end
    sig_shift = 1'b0;
  endtask

  task automatic settle_clear();
    tick(WAITC);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    tick(PASS + 40);
  endtask

  task automatic restore();
    for (int a = 0; a < DEPTH; a++) if (mdl[a] != good[a]) host_write(a, good[a]);
  endtask

  task automatic check_err(input string req, input int mask);
    if (mask == 0) begin
      chk(req, "err_flag with all frames valid", err_flag, 0);
    end else begin
      chk(req, "err_flag with corrupted frame", err_flag, 1);
      if ((mask & (mask - 1)) == 0) chk(req, "err_frame", err_frame, $clog2(mask));
      else chk(req, "err_frame within failing set", (mask >> err_frame) & 1, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, s;
    int pa, pb, md;
    void'($urandom(32'd2718));
    rst = 1'b1; host_addr = '0; host_we = 1'b0; host_wdata = '0;
    inj_req = 1'b0; inj_mode = 2'b00; inj_pos_a = '0; inj_pos_b = '0;
    err_clr = 1'b0; sig_load = 1'b0; sig_shift = 1'b0;
    for (int a = 0; a < DEPTH; a++) mdl[a] = '0;
    tick(3);
    chk("R1", "err_flag in reset", err_flag, 0);
    chk("R1", "err_frame in reset", err_frame, 0);
    chk("R1", "inj_busy in reset", inj_busy, 0);
    chk("R1", "sig_dout in reset", sig_dout, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "err_flag after reset", err_flag, 0);
    mem_compare("R1");

    // Valid contents everywhere
    for (int f = 0; f < NF; f++) fill_frame(f);
    host_read(5, d);
    chk("R9", "host read back", d, mdl[5]);
    mem_compare("R9");
    settle_clear();
    check_err("R2", 0);
    read_sig(s);
    chk("R6", "frame 0 signature on valid frame", s, 0);
    good = mdl;

    // Mode 00 is not accepted
    inject(2'b00, 7, 0);
    mem_compare("R7");

    // Single corrupted frame, then newer failure overwrites without clear
    host_write(2*FL+3, mdl[2*FL+3] ^ 16'h0100);
    tick(WAITC);
    check_err("R3", 1 << 2);
    restore();
    host_write(1*FL, mdl[1*FL] ^ 16'h0001);
    tick(WAITC);
    chk("R4", "err_frame replaced by newer failure", err_frame, 1);
    chk("R4", "err_flag still set", err_flag, 1);
    restore();
    settle_clear();
    chk("R5", "err_flag after clear", err_flag, 0);
    chk("R5", "err_frame after clear", err_frame, 0);

    // Second request while busy is ignored
    pa = 3*FL*16 + 37;
    pb = 1*FL*16 + 5;
    inj_mode = 2'b01; inj_pos_a = PW'(pa); inj_req = 1'b1;
    @(negedge clk);
    chk("R8", "busy after first request", inj_busy, 1);
    inj_pos_a = PW'(pb);
    @(negedge clk);
    inj_req = 1'b0;
    wait_idle();
    flip_mdl(pa);
    mem_compare("R8");
    tick(WAITC);
    check_err("R8", bad_mask());
    restore();
    settle_clear();
    chk("R5", "err_flag after repair", err_flag, 0);

    // Adjacent flip wrapping from the last bit to bit 0
    inject(2'b11, TOTAL - 1, 0);
    mem_compare("R7");
    tick(WAITC);
    check_err("R7", bad_mask());
    read_sig(s);
    chk("R6", "frame 0 signature after wrap flip", s, frame_res(0));
    restore();
    settle_clear();
    chk("R5", "err_flag after repair", err_flag, 0);

    // Random flip trials
    for (int t = 0; t < 10; t++) begin
      md = 1 + int'($urandom % 3);
      pa = int'($urandom % TOTAL);
      do pb = int'($urandom % TOTAL); while (pb == pa);
      inject(2'(md), pa, pb);
      mem_compare("R7");
      tick(WAITC);
      check_err("R3", bad_mask());
      read_sig(s);
      chk("R6", "frame 0 signature", s, frame_res(0));
      restore();
      settle_clear();
      chk("R5", "err_flag after repair", err_flag, 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule